// File: doc/BRIEF.md
# Pairwise Data Hazard Classifier

This block takes two instructions, an older one (i) and a younger one (j), and reports which data-dependency hazards link them. Each instruction is described by the register locations it reads (a fixed number of source slots, each with its own valid bit) and the one location it writes (a destination index with a valid bit). The block forms the read set and the write set of each instruction and intersects them three ways. The result is a true-dependency flag (read-after-write), an anti-dependency flag (write-after-read), an output-dependency flag (write-after-write) and a combined flag.

A pair is presented together with an input strobe. One clock later the block raises an output strobe along with the four registered flags. A slot whose valid bit is clear, such as a slot that holds an immediate operand, is not a member of any set. Register index 0 never takes part in a match. An issue or scoreboard stage would use the flags to decide whether to stall or reorder the younger instruction. That decision is not made here.

Top module: `hzd_pair_top`

## Requirements
- R1: One cycle after a pair is accepted, `raw` is 1 exactly when i's destination is valid and nonzero and equals some valid source slot of j.
- R2: One cycle after a pair is accepted, `war` is 1 exactly when j's destination is valid and nonzero and equals some valid source slot of i.
- R3: One cycle after a pair is accepted, `waw` is 1 exactly when both destinations are valid and nonzero and are equal to each other.
- R4: Register index 0 never produces a match in any of the three intersections, even when both sides are valid.
- R5: A source or destination slot whose valid bit is 0 contributes no match, whatever index it carries. Source slot k sits at bits [k*REG_W +: REG_W], and its valid bit is bit k of the matching valid vector.
- R6: `any_hz` is the OR of `raw`, `war` and `waw`.
- R7: `out_vld` at a rising edge equals `in_vld` sampled at the previous rising edge, so results appear one cycle after a pair is presented.
- R8: While `out_vld` is 0, all four flags are 0.
- R9: While `rst_n` is low, all outputs are 0.
- R10: For i writing 3 and reading 1 and 2, and j writing 2 and reading 3, the block reports `raw`=1, `war`=1 and `waw`=0.
- R11: When several valid source slots of one instruction carry the same index, the flags are the same as when that index appears in only one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A pair is presented this cycle |
| i_dst | input | REG_W | Destination index of older instruction |
| i_dst_vld | input | 1 | Older instruction writes a register |
| i_src | input | NSRC*REG_W | Source indices of older instruction, slot k at [k*REG_W +: REG_W] |
| i_src_vld | input | NSRC | Per-slot source valid of older instruction |
| j_dst | input | REG_W | Destination index of younger instruction |
| j_dst_vld | input | 1 | Younger instruction writes a register |
| j_src | input | NSRC*REG_W | Source indices of younger instruction |
| j_src_vld | input | NSRC | Per-slot source valid of younger instruction |
| out_vld | output | 1 | Flags below are valid |
| raw | output | 1 | Read-after-write hazard |
| war | output | 1 | Write-after-read hazard |
| waw | output | 1 | Write-after-write hazard |
| any_hz | output | 1 | Any of the three hazards |

## Verification
Random pairs draw indices from a narrow range, so matches, misses and the zero index all occur often, and every valid bit is randomized independently. This separates a correct intersection from one that ignores valid bits or lets index 0 match. Directed pairs cover the worked example, sets that overlap in only one direction, equal destinations, repeated source indices and fully invalid descriptors. These distinguish swapped i and j roles and a missing WAW path. Idle cycles between pairs show whether the flags stay clear when no pair is presented and whether the one-cycle latency is correct.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REG_W_DEF = 5;
    localparam int NSRC_DEF  = 2;

    typedef struct packed {
        logic raw;
        logic war;
        logic waw;
    } hz_flags_t;
endpackage

// File: rtl/hzd_match.sv
// Membership test: does a single valid location appear in a set of locations?
module hzd_match #(
    parameter int REG_W = 5,
    parameter int NSET  = 2
) (
    input  logic [REG_W-1:0]      loc,
    input  logic                  loc_vld,
    input  logic [NSET*REG_W-1:0] set_idx,
    input  logic [NSET-1:0]       set_vld,
    output logic                  hit
);
    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    logic [NSET-1:0] slot_eq;
    logic            loc_live;

    // index 0 is never a member of any set
    assign loc_live = loc_vld && (loc != ZERO_IDX);

    generate
        for (genvar k = 0; k < NSET; k++) begin : g_slot
            assign slot_eq[k] = set_vld[k] && (set_idx[k*REG_W +: REG_W] == loc);
        end
    endgenerate

    assign hit = loc_live && (|slot_eq);
endmodule

// File: rtl/hzd_classify.sv
// Combinational three-way set intersection between an older and a younger instruction.
module hzd_classify
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic [REG_W-1:0]      i_dst,
    input  logic                  i_dst_vld,
    input  logic [NSRC*REG_W-1:0] i_src,
    input  logic [NSRC-1:0]       i_src_vld,
    input  logic [REG_W-1:0]      j_dst,
    input  logic                  j_dst_vld,
    input  logic [NSRC*REG_W-1:0] j_src,
    input  logic [NSRC-1:0]       j_src_vld,
    output hz_flags_t             flags
);
    logic raw_hit, war_hit, waw_hit;

    // write set of i against read set of j
    hzd_match #(.REG_W(REG_W), .NSET(NSRC)) u_raw (
        .loc(i_dst), .loc_vld(i_dst_vld),
        .set_idx(j_src), .set_vld(j_src_vld), .hit(raw_hit)
    );

    // write set of j against read set of i
    hzd_match #(.REG_W(REG_W), .NSET(NSRC)) u_war (
        .loc(j_dst), .loc_vld(j_dst_vld),
        .set_idx(i_src), .set_vld(i_src_vld), .hit(war_hit)
    );

    // write set of i against write set of j
    hzd_match #(.REG_W(REG_W), .NSET(1)) u_waw (
        .loc(i_dst), .loc_vld(i_dst_vld),
        .set_idx(j_dst), .set_vld(j_dst_vld), .hit(waw_hit)
    );

    always_comb begin
        flags.raw = raw_hit;
        flags.war = war_hit;
        flags.waw = waw_hit;
    end
endmodule

// File: rtl/hzd_pair_top.sv
module hzd_pair_top
    import hzd_pkg::*;
#(
    parameter int REG_W = REG_W_DEF,
    parameter int NSRC  = NSRC_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [REG_W-1:0]      i_dst,
    input  logic                  i_dst_vld,
    input  logic [NSRC*REG_W-1:0] i_src,
    input  logic [NSRC-1:0]       i_src_vld,
    input  logic [REG_W-1:0]      j_dst,
    input  logic                  j_dst_vld,
    input  logic [NSRC*REG_W-1:0] j_src,
    input  logic [NSRC-1:0]       j_src_vld,
    output logic                  out_vld,
    output logic                  raw,
    output logic                  war,
    output logic                  waw,
    output logic                  any_hz
);
    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    hz_flags_t nxt_flags;

    hzd_classify #(.REG_W(REG_W), .NSRC(NSRC)) u_cls (
        .i_dst(i_dst), .i_dst_vld(i_dst_vld),
        .i_src(i_src), .i_src_vld(i_src_vld),
        .j_dst(j_dst), .j_dst_vld(j_dst_vld),
        .j_src(j_src), .j_src_vld(j_src_vld),
        .flags(nxt_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            raw     <= 1'b0;
            war     <= 1'b0;
            waw     <= 1'b0;
            any_hz  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            raw     <= in_vld && nxt_flags.raw;
            war     <= in_vld && nxt_flags.war;
            waw     <= in_vld && nxt_flags.waw;
            any_hz  <= in_vld && (|nxt_flags);
        end
    end

    // R7
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !(raw || war || waw || any_hz));

    // R6
    any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hz == (raw || war || waw));

    // R3
    waw_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && i_dst_vld && j_dst_vld && i_dst == j_dst && i_dst != ZERO_IDX) |=> waw);

    // R4
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && i_dst == ZERO_IDX) |=> !(raw || waw));

    // R5
    no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !j_dst_vld) |=> !(war || waw));
endmodule

// File: tb/sim_hzd_pair_top.sv
`timescale 1ns/1ps
module sim_hzd_pair_top;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_vld = 1'b0;
    logic [REG_W-1:0]      i_dst = '0;
    logic                  i_dst_vld = 1'b0;
    logic [NSRC*REG_W-1:0] i_src = '0;
    logic [NSRC-1:0]       i_src_vld = '0;
    logic [REG_W-1:0]      j_dst = '0;
    logic                  j_dst_vld = 1'b0;
    logic [NSRC*REG_W-1:0] j_src = '0;
    logic [NSRC-1:0]       j_src_vld = '0;
    logic out_vld, raw, war, waw, any_hz;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hzd_pair_top #(.REG_W(REG_W), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .i_dst(i_dst), .i_dst_vld(i_dst_vld), .i_src(i_src), .i_src_vld(i_src_vld),
        .j_dst(j_dst), .j_dst_vld(j_dst_vld), .j_src(j_src), .j_src_vld(j_src_vld),
        .out_vld(out_vld), .raw(raw), .war(war), .waw(waw), .any_hz(any_hz)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // does valid nonzero location d appear among the valid slots of s?
    function automatic bit in_set(input logic [REG_W-1:0] d, input bit dv,
                                  input logic [NSRC*REG_W-1:0] s, input logic [NSRC-1:0] sv);
        bit r = 0;
        if (!dv || d == 0) return 0;
        for (int k = 0; k < NSRC; k++)
            if (sv[k] && s[k*REG_W +: REG_W] == d) r = 1;
        return r;
    endfunction

    task automatic present(input logic [REG_W-1:0] id, input bit idv,
                           input logic [NSRC*REG_W-1:0] is, input logic [NSRC-1:0] isv,
                           input logic [REG_W-1:0] jd, input bit jdv,
                           input logic [NSRC*REG_W-1:0] js, input logic [NSRC-1:0] jsv,
                           input string tag);
        bit e_raw, e_war, e_waw;
        @(negedge clk);
        in_vld = 1; i_dst = id; i_dst_vld = idv; i_src = is; i_src_vld = isv;
        j_dst = jd; j_dst_vld = jdv; j_src = js; j_src_vld = jsv;
        e_raw = in_set(id, idv, js, jsv);
        e_war = in_set(jd, jdv, is, isv);
        e_waw = idv && jdv && (id != 0) && (id == jd);
        @(posedge clk); #1;
        chk({tag, " R7 out_vld"}, out_vld, 1'b1);
        chk({tag, " R1 raw"}, raw, e_raw);
        chk({tag, " R2 war"}, war, e_war);
        chk({tag, " R3 waw"}, waw, e_waw);
        chk({tag, " R6 any"}, any_hz, e_raw | e_war | e_waw);
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_vld = 0;
        @(posedge clk); #1;
        chk("R8 idle out_vld", out_vld, 1'b0);
        chk("R8 idle flags", raw | war | waw | any_hz, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset out_vld", out_vld, 1'b0);
        chk("R9 reset flags", raw | war | waw | any_hz, 1'b0);
        @(negedge clk); rst_n = 1;

        // R10 worked example: i writes 3 reads {1,2}; j writes 2 reads {3,0 invalid}
        present(5'd3, 1, {5'd2, 5'd1}, 2'b11, 5'd2, 1, {5'd0, 5'd3}, 2'b01, "R10");
        chk("R10 raw", raw, 1'b1);
        chk("R10 war", war, 1'b1);
        chk("R10 waw", waw, 1'b0);
        idle_check();
        // R3 equal destinations only
        present(5'd7, 1, {5'd1, 5'd2}, 2'b11, 5'd7, 1, {5'd4, 5'd5}, 2'b11, "R3 eqdst");
        // R4 zero index everywhere
        present(5'd0, 1, {5'd0, 5'd0}, 2'b11, 5'd0, 1, {5'd0, 5'd0}, 2'b11, "R4 zero");
        chk("R4 none", any_hz, 1'b0);
        // R5 invalid slots carrying matching indices
        present(5'd9, 0, {5'd6, 5'd6}, 2'b00, 5'd9, 0, {5'd9, 5'd9}, 2'b00, "R5 inval");
        chk("R5 none", any_hz, 1'b0);
        // R11 duplicate source indices, one slot invalid then both valid
        present(5'd4, 1, {5'd8, 5'd8}, 2'b10, 5'd8, 1, {5'd4, 5'd4}, 2'b11, "R11 dup");
        chk("R11 raw", raw, 1'b1);
        chk("R11 war", war, 1'b1);
        // R2 only anti
        present(5'd1, 1, {5'd12, 5'd11}, 2'b11, 5'd12, 1, {5'd2, 5'd3}, 2'b11, "R2 anti");
        idle_check();

        for (int n = 0; n < 400; n++) begin
            present(5'($urandom_range(0, 7)), 1'($urandom),
                    {5'($urandom_range(0, 7)), 5'($urandom_range(0, 7))}, 2'($urandom),
                    5'($urandom_range(0, 7)), 1'($urandom),
                    {5'($urandom_range(0, 7)), 5'($urandom_range(0, 7))}, 2'($urandom),
                    "rnd");
            if ($urandom_range(0, 4) == 0) idle_check();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule